// File: doc/BRIEF.md
# Converter Fault Protection Supervisor

This block decides whether a step-down power stage may run. Each clock it compares sampled output-voltage, output-current and die-temperature codes against limits derived from the programmed voltage setpoint and from fixed parameters. It also combines an enable pin with a polarity strap and watches a shared open-drain fault line. The result is a single run/stop command for the power stage, plus a pull-low request for the shared fault line.

An overvoltage trip latches the stage off until enable is withdrawn and applied again. Undervoltage, overcurrent and overtemperature trips instead start a hiccup wait that is counted in clock-enable ticks. The stage retries when that wait ends, and for a temperature trip only after the die has cooled below a lower release limit. Undervoltage checking is masked while the soft-start generator reports a ramp in progress. An outside circuit that pulls the shared fault line low forces the stage off. The stage resumes once the line is released.

Top module: `conv_guard`

## Requirements
- R1: When the stage is running and vOutCode*10 > vSetCode*13 and vOutCode > OV_FLOOR, runCmd falls within 2 clock cycles of the sample, faultPullLow rises, and the stage does not restart on its own.
- R2: When 130% of the setpoint lies below OV_FLOOR, an output code above 130% of the setpoint but not above OV_FLOOR does not trip; a code above OV_FLOOR does.
- R3: The overvoltage latch holds the stage off while the effective enable stays asserted. It clears only through reset or through an effective-enable deassertion, after which a reassertion restarts the stage.
- R4: While running with rampActive low, vOutCode*4 < vSetCode*3 stops the stage and starts a hiccup wait.
- R5: While rampActive is 1, a low output voltage causes no trip.
- R6: iOutCode > I_RATED*14/10 stops the stage and starts a hiccup wait; a code equal to that limit does not.
- R7: tempCode >= OT_TRIP stops the stage. A restart needs tempCode < OT_CLEAR, so a code between the two limits keeps the stage off.
- R8: A hiccup keeps runCmd low and faultPullLow high for HICCUP_TICKS ticks of TICK_DIV clocks each; then the stage restarts if enabled and no fault is present.
- R9: The effective enable equals enPin when enPolStrap is 1 and equals the inverse of enPin when enPolStrap is 0.
- R10: faultLineIn low, while the block is not pulling the line itself, forces runCmd low without asserting faultPullLow; the stage restarts after the line returns high.
- R11: After reset, runCmd and faultPullLow are both 0.
- R12: When an overvoltage and a retrying fault are seen in the same cycle, the overvoltage latch wins and no hiccup retry follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vOutCode | input | V_W | Sampled output voltage code |
| vSetCode | input | V_W | Programmed setpoint code, same scale |
| iOutCode | input | I_W | Sampled output current code |
| tempCode | input | T_W | Die temperature code, one LSB per degree |
| rampActive | input | 1 | Soft-start ramp in progress |
| enPin | input | 1 | Enable pin, asynchronous |
| enPolStrap | input | 1 | 1 = active-high enable, 0 = active-low |
| faultLineIn | input | 1 | Level sensed on the shared fault line |
| runCmd | output | 1 | Power-stage run command |
| faultPullLow | output | 1 | Request to pull the shared fault line low |

## Verification
The hardest situation to reach is the temperature release band. A hot die must first cause a trip, and then stay between the two limits past a whole hiccup window, so the test can show the timer alone does not restart the stage. The bench raises the temperature code to the trip limit, lowers it to a mid-band value, waits several hiccup periods, and only then drops it below the release limit. The overvoltage floor needs a matching trick: setpoint and output are moved together under an active ramp, so that neither an overvoltage nor an undervoltage trip fires in between.

// File: rtl/conv_guard_pkg.sv
package conv_guard_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RUN     = 2'd1,
    ST_HICCUP  = 2'd2,
    ST_OVLATCH = 2'd3
  } guard_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic hicLoad;
    logic uvArm;
  } ctl_strobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic ov;
    logic uv;
    logic oc;
    logic hot;
    logic hicDone;
    logic lineHigh;
    logic enOn;
  } dp_flag_t;

endpackage

// File: rtl/conv_guard_dp.sv
module conv_guard_dp
  import conv_guard_pkg::*;
#(
  parameter int V_W          = 12,
  parameter int I_W          = 12,
  parameter int T_W          = 8,
  parameter int OV_FLOOR     = 400,
  parameter int I_RATED      = 1000,
  parameter int OT_TRIP      = 120,
  parameter int OT_CLEAR     = 110,
  parameter int TICK_DIV     = 50,
  parameter int HICCUP_TICKS = 130000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [V_W-1:0]  vOutCode,
  input  logic [V_W-1:0]  vSetCode,
  input  logic [I_W-1:0]  iOutCode,
  input  logic [T_W-1:0]  tempCode,
  input  logic            rampActive,
  input  logic            enPin,
  input  logic            enPolStrap,
  input  logic            faultLineIn,
  input  ctl_strobe_t     strobe,
  output dp_flag_t        flags
);

  localparam int PROD_W = V_W + 4;
  localparam int HIC_W  = $clog2(HICCUP_TICKS + 1);
  localparam logic [V_W-1:0] OV_FLOOR_C = V_W'(OV_FLOOR);
  localparam logic [I_W:0]   OC_LIM_C   = (I_W+1)'((I_RATED * 14) / 10);
  localparam logic [T_W-1:0] OT_TRIP_C  = T_W'(OT_TRIP);
  localparam logic [T_W-1:0] OT_CLEAR_C = T_W'(OT_CLEAR);
  localparam logic [HIC_W-1:0] HIC_END  = HIC_W'(HICCUP_TICKS);

  // pin synchronisers
  logic [1:0] enSync, lineSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSync   <= 2'b00;
      lineSync <= 2'b11;
    end else begin
      enSync   <= {enSync[0], enPin};
      lineSync <= {lineSync[0], faultLineIn};
    end
  end

  // scaled comparisons
  logic [PROD_W-1:0] vOutX10, vSetX13, vOutX4, vSetX3;
  always_comb begin
    vOutX10 = PROD_W'(vOutCode) * PROD_W'(10);
    vSetX13 = PROD_W'(vSetCode) * PROD_W'(13);
    vOutX4  = PROD_W'(vOutCode) * PROD_W'(4);
    vSetX3  = PROD_W'(vSetCode) * PROD_W'(3);
  end

  logic ovRaw, uvRaw, ocRaw;
  assign ovRaw = (vOutX10 > vSetX13) && (vOutCode > OV_FLOOR_C);
  assign uvRaw = strobe.uvArm && !rampActive && (vOutX4 < vSetX3);
  assign ocRaw = {1'b0, iOutCode} > OC_LIM_C;

  logic ovQ, uvQ, ocQ, hotQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovQ  <= 1'b0;
      uvQ  <= 1'b0;
      ocQ  <= 1'b0;
      hotQ <= 1'b0;
    end else begin
      ovQ <= ovRaw;
      uvQ <= uvRaw;
      ocQ <= ocRaw;
      if (tempCode >= OT_TRIP_C)      hotQ <= 1'b1;
      else if (tempCode < OT_CLEAR_C) hotQ <= 1'b0;
    end
  end

  // clock-enable tick
  logic tick;
  generate
    if (TICK_DIV <= 1) begin : g_tick_every
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] DIV_END = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                divCnt <= '0;
        else if (divCnt == DIV_END) divCnt <= '0;
        else                      divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_END);
    end
  endgenerate

  // hiccup timer
  logic [HIC_W-1:0] hicCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          hicCnt <= '0;
    else if (strobe.hicLoad)            hicCnt <= '0;
    else if (tick && hicCnt != HIC_END) hicCnt <= hicCnt + 1'b1;
  end

  always_comb begin
    flags.ov       = ovQ;
    flags.uv       = uvQ;
    flags.oc       = ocQ;
    flags.hot      = hotQ;
    flags.hicDone  = (hicCnt == HIC_END);
    flags.lineHigh = lineSync[1];
    flags.enOn     = enPolStrap ? enSync[1] : ~enSync[1];
  end

endmodule

// File: rtl/conv_guard_ctl.sv
module conv_guard_ctl
  import conv_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dp_flag_t     flags,
  output ctl_strobe_t  strobe,
  output guard_state_e state,
  output logic         runCmd,
  output logic         faultPullLow
);

  guard_state_e nextState;
  logic retryFault;

  assign retryFault = flags.uv || flags.oc || flags.hot;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF: begin
        if (flags.enOn && flags.lineHigh && !flags.hot) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (flags.ov)              nextState = ST_OVLATCH;
        else if (retryFault)       nextState = ST_HICCUP;
        else if (!flags.lineHigh)  nextState = ST_OFF;
        else if (!flags.enOn)      nextState = ST_OFF;
      end
      ST_HICCUP: begin
        if (flags.hicDone && !flags.hot) nextState = ST_OFF;
      end
      ST_OVLATCH: begin
        if (!flags.enOn) nextState = ST_OFF;
      end
      default: nextState = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strobe.hicLoad = (state == ST_RUN) && (nextState == ST_HICCUP);
    strobe.uvArm   = (state == ST_RUN);
  end

  assign runCmd       = (state == ST_RUN);
  assign faultPullLow = (state == ST_HICCUP) || (state == ST_OVLATCH);

endmodule

// File: rtl/conv_guard.sv
module conv_guard
  import conv_guard_pkg::*;
#(
  parameter int V_W          = 12,
  parameter int I_W          = 12,
  parameter int T_W          = 8,
  parameter int OV_FLOOR     = 400,
  parameter int I_RATED      = 1000,
  parameter int OT_TRIP      = 120,
  parameter int OT_CLEAR     = 110,
  parameter int TICK_DIV     = 50,
  parameter int HICCUP_TICKS = 130000
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [V_W-1:0] vOutCode,
  input  logic [V_W-1:0] vSetCode,
  input  logic [I_W-1:0] iOutCode,
  input  logic [T_W-1:0] tempCode,
  input  logic           rampActive,
  input  logic           enPin,
  input  logic           enPolStrap,
  input  logic           faultLineIn,
  output logic           runCmd,
  output logic           faultPullLow
);

  ctl_strobe_t  ctlStrobe;
  dp_flag_t     dpFlags;
  guard_state_e ctlState;

  conv_guard_dp #(
    .V_W(V_W), .I_W(I_W), .T_W(T_W), .OV_FLOOR(OV_FLOOR),
    .I_RATED(I_RATED), .OT_TRIP(OT_TRIP), .OT_CLEAR(OT_CLEAR),
    .TICK_DIV(TICK_DIV), .HICCUP_TICKS(HICCUP_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .vOutCode(vOutCode), .vSetCode(vSetCode),
    .iOutCode(iOutCode), .tempCode(tempCode), .rampActive(rampActive),
    .enPin(enPin), .enPolStrap(enPolStrap), .faultLineIn(faultLineIn),
    .strobe(ctlStrobe), .flags(dpFlags)
  );

  conv_guard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .flags(dpFlags), .strobe(ctlStrobe),
    .state(ctlState), .runCmd(runCmd), .faultPullLow(faultPullLow)
  );

endmodule

// File: rtl/conv_guard_chk.sv
module conv_guard_chk
  import conv_guard_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input guard_state_e state,
  input dp_flag_t     flags,
  input logic         runCmd,
  input logic         faultPullLow,
  input logic         rampActive
);

  p_ov_stop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (flags.ov && state == ST_RUN) |=> (state == ST_OVLATCH && !runCmd));

  p_ov_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OVLATCH && flags.enOn) |=> (state == ST_OVLATCH));

  p_uv_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    rampActive |=> !flags.uv);

  p_hiccup_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HICCUP && !flags.hicDone) |=> (state == ST_HICCUP && faultPullLow));

  p_line_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!flags.lineHigh && !faultPullLow) |=> !runCmd);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(runCmd && faultPullLow));

endmodule

bind conv_guard conv_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .state(ctlState), .flags(dpFlags),
  .runCmd(runCmd), .faultPullLow(faultPullLow), .rampActive(rampActive)
);

// File: tb/tb_conv_guard.sv
module tb_conv_guard;

  localparam int TDIV = 4;
  localparam int HTK  = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] vOutCode = 12'd1000;
  logic [11:0] vSetCode = 12'd1000;
  logic [11:0] iOutCode = 12'd500;
  logic [7:0]  tempCode = 8'd50;
  logic        rampActive = 1'b0;
  logic        enPin = 1'b1;
  logic        enPolStrap = 1'b1;
  logic        faultLineIn = 1'b1;
  logic        runCmd, faultPullLow;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  conv_guard #(.TICK_DIV(TDIV), .HICCUP_TICKS(HTK)) dut (
    .clk(clk), .rstN(rstN), .vOutCode(vOutCode), .vSetCode(vSetCode),
    .iOutCode(iOutCode), .tempCode(tempCode), .rampActive(rampActive),
    .enPin(enPin), .enPolStrap(enPolStrap), .faultLineIn(faultLineIn),
    .runCmd(runCmd), .faultPullLow(faultPullLow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nRun = nRun + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    cyc(3);
    chk("R11 runCmd in reset", runCmd, 1'b0);
    chk("R11 faultPullLow in reset", faultPullLow, 1'b0);
    rstN = 1'b1;
    cyc(5);
    chk("R9 active-high enable starts", runCmd, 1'b1);
  endtask

  task automatic toggle_enable();
    enPin = 1'b0;
    cyc(5);
    enPin = 1'b1;
    cyc(5);
  endtask

  task automatic test_ov_latch();
    vOutCode = 12'd1400;
    cyc(2);
    chk("R1 stop within 2 cycles", runCmd, 1'b0);
    chk("R1 fault line pulled", faultPullLow, 1'b1);
    vOutCode = 12'd1000;
    cyc(3 * HTK * TDIV);
    chk("R3 latch holds", runCmd, 1'b0);
    enPin = 1'b0;
    cyc(5);
    chk("R3 disable clears latch", faultPullLow, 1'b0);
    enPin = 1'b1;
    cyc(5);
    chk("R3 re-enable restarts", runCmd, 1'b1);
  endtask

  task automatic test_ov_floor();
    rampActive = 1'b1;
    vSetCode = 12'd200;
    vOutCode = 12'd300;
    cyc(2);
    rampActive = 1'b0;
    cyc(5);
    chk("R2 below floor no trip", runCmd, 1'b1);
    vOutCode = 12'd401;
    cyc(2);
    chk("R2 above floor trips", runCmd, 1'b0);
    chk("R2 above floor latched", faultPullLow, 1'b1);
    enPin = 1'b0;
    cyc(2);
    vSetCode = 12'd1000;
    vOutCode = 12'd1000;
    cyc(4);
    enPin = 1'b1;
    cyc(5);
    chk("R2 recovered", runCmd, 1'b1);
  endtask

  task automatic test_oc_hiccup();
    iOutCode = 12'd1400;
    cyc(5);
    chk("R6 at limit no trip", runCmd, 1'b1);
    iOutCode = 12'd1401;
    cyc(2);
    chk("R6 above limit stops", runCmd, 1'b0);
    iOutCode = 12'd500;
    cyc(HTK * TDIV - 10);
    chk("R8 still off before period", runCmd, 1'b0);
    chk("R8 line pulled during hiccup", faultPullLow, 1'b1);
    cyc(20);
    chk("R8 retry after period", runCmd, 1'b1);
    chk("R8 line released", faultPullLow, 1'b0);
  endtask

  task automatic test_uv();
    vOutCode = 12'd700;
    cyc(2);
    chk("R4 undervoltage stops", runCmd, 1'b0);
    vOutCode = 12'd1000;
    cyc(HTK * TDIV + 20);
    chk("R4 retry after UV", runCmd, 1'b1);
    rampActive = 1'b1;
    vOutCode = 12'd200;
    cyc(10);
    chk("R5 ramp masks UV", runCmd, 1'b1);
    chk("R5 no fault during ramp", faultPullLow, 1'b0);
    vOutCode = 12'd1000;
    cyc(1);
    rampActive = 1'b0;
    cyc(3);
  endtask

  task automatic test_ot();
    tempCode = 8'd119;
    cyc(5);
    chk("R7 below trip runs", runCmd, 1'b1);
    tempCode = 8'd120;
    cyc(2);
    chk("R7 trip stops", runCmd, 1'b0);
    tempCode = 8'd115;
    cyc(3 * HTK * TDIV);
    chk("R7 mid band stays off", runCmd, 1'b0);
    tempCode = 8'd109;
    cyc(HTK * TDIV + 20);
    chk("R7 cooled restarts", runCmd, 1'b1);
    tempCode = 8'd50;
  endtask

  task automatic test_line();
    faultLineIn = 1'b0;
    cyc(4);
    chk("R10 external low stops", runCmd, 1'b0);
    chk("R10 no own pull", faultPullLow, 1'b0);
    faultLineIn = 1'b1;
    cyc(5);
    chk("R10 release resumes", runCmd, 1'b1);
  endtask

  task automatic test_polarity();
    enPolStrap = 1'b0;
    cyc(3);
    chk("R9 active-low high pin off", runCmd, 1'b0);
    enPin = 1'b0;
    cyc(5);
    chk("R9 active-low low pin on", runCmd, 1'b1);
    enPolStrap = 1'b1;
    enPin = 1'b1;
    cyc(8);
    chk("R9 restore", runCmd, 1'b1);
  endtask

  task automatic test_priority();
    vOutCode = 12'd1400;
    iOutCode = 12'd1500;
    cyc(2);
    vOutCode = 12'd1000;
    iOutCode = 12'd500;
    cyc(3 * HTK * TDIV);
    chk("R12 OV wins, no retry", runCmd, 1'b0);
    chk("R12 latched fault", faultPullLow, 1'b1);
    toggle_enable();
    chk("R12 recovered", runCmd, 1'b1);
  endtask

  initial begin
    test_reset();
    test_ov_latch();
    test_ov_floor();
    test_oc_hiccup();
    test_uv();
    test_ot();
    test_line();
    test_polarity();
    test_priority();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule